// File: doc/BRIEF.md
# Gated 13/16-bit Counter/Timer

This block is one counter/timer channel with a small register interface. Software reaches three registers through a write port and a combinational read port: a control register, the low count byte and the high count byte. The count runs either as a 13-bit value or as a full 16-bit value. It advances on an internal timebase, which is either every system clock or one clock in twelve, or on falling edges of an external count input.

A software run bit starts and stops the count. When the gate-enable bit is set, the count also needs an external active-high gate input to be high. A pulse on the gate input then leaves its width, in timebase ticks, in the count registers. Setting the run bit leaves the count as it is, so software loads a start value first. When the count rolls over to zero, a sticky overflow flag is set in the control register. All logic runs in one clock domain. The divide-by-twelve timebase is a one-cycle enable pulse, not a derived clock.

Top module: `gated_timer`

## Requirements
- R1: After a synchronous reset, the control register, both count bytes and the overflow flag read 0x00 or 0. Address 3 always reads 0x00.
- R2: Address 0 is the control register, with these fields: bits [1:0] select the mode, bit 2 selects the external count input, bit 3 enables gating, bit 4 is run, bit 5 selects the undivided clock, bit 6 always reads 0 and bit 7 is the overflow flag. Address 1 is the low byte and address 2 is the high byte. Written fields read back unchanged. Writing the control register never changes the count bytes.
- R3: The count steps only while run is 1 and either gate-enable is 0 or the gate input is 1. In every other case both count bytes hold.
- R4: With bit 2 = 0 the count steps on every clock when bit 5 = 1, and once in every 12 clocks when bit 5 = 0.
- R5: With bit 2 = 1 the count steps once for each falling edge of the count input, three clocks after that edge. The input passes through a two-stage synchronizer. Rising edges and the internal timebase have no effect.
- R6: Any mode value other than 00 is 16-bit mode. The high byte and the low byte form one 16-bit count that wraps from 0xFFFF to 0x0000.
- R7: Mode 00 is 13-bit mode. Low bits [4:0] are the lower part of the count and the high byte is the upper part. The count wraps from 0x1FFF to 0. Low bits [7:5] keep their written value.
- R8: In the clock where the count wraps, the flag is set. It stays set until a control write with bit 7 = 0. If a wrap and such a write fall in the same clock, the flag ends up set.
- R9: A write to a count byte loads that byte and suppresses the step in that clock. The other byte keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Read data (combinational) |
| gate_in | input | 1 | External active-high gate, synchronous to clk |
| cnt_in | input | 1 | External count input, asynchronous |
| ovf_flag | output | 1 | Sticky overflow flag (control bit 7) |

## Verification
Two pairs of events can land on the same clock. A count step can meet a software write to a count byte. A wrap can meet a control write that clears the flag. The bench lets the count run on the undivided clock and issues each write on the exact clock where a step, or the 0xFFFF wrap, is due. It then reads the registers one clock later. The written byte must be present, with no step in either byte, and the flag must still be set.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;

    localparam int DW       = 8;
    localparam int CW       = 2 * DW;
    localparam int LO13_W   = 5;
    localparam int AW       = 2;

    localparam logic [AW-1:0] ADDR_CTRL = 2'd0;
    localparam logic [AW-1:0] ADDR_LO   = 2'd1;
    localparam logic [AW-1:0] ADDR_HI   = 2'd2;

    typedef enum logic [1:0] {
        MODE_13  = 2'b00,
        MODE_16  = 2'b01,
        MODE_X2  = 2'b10,
        MODE_X3  = 2'b11
    } mode_e;

    typedef struct packed {
        logic  ovf;
        logic  rsv;
        logic  fast;
        logic  run;
        logic  gate_en;
        logic  ext_sel;
        mode_e mode;
    } ctrl_t;

    typedef struct packed {
        logic [DW-1:0] lo;
        logic [DW-1:0] hi;
        logic          wrap;
    } count_nxt_t;

    function automatic count_nxt_t count_step(input logic mode13,
                                              input logic [DW-1:0] lo,
                                              input logic [DW-1:0] hi);
        count_nxt_t r;
        logic [CW:0] sum16;
        logic [LO13_W:0] sum_lo;
        logic [DW:0] sum_hi;
        r = '0;
        if (mode13) begin
            sum_lo = {1'b0, lo[LO13_W-1:0]} + 1'b1;
            sum_hi = {1'b0, hi} + {{DW{1'b0}}, sum_lo[LO13_W]};
            r.lo   = {lo[DW-1:LO13_W], sum_lo[LO13_W-1:0]};
            r.hi   = sum_hi[DW-1:0];
            r.wrap = sum_hi[DW];
        end else begin
            sum16  = {1'b0, hi, lo} + 1'b1;
            r.lo   = sum16[DW-1:0];
            r.hi   = sum16[CW-1:DW];
            r.wrap = sum16[CW];
        end
        return r;
    endfunction

    function automatic ctrl_t ctrl_from_byte(input logic [DW-1:0] b);
        ctrl_t c;
        c      = ctrl_t'(b);
        c.rsv  = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/gtmr_prescaler.sv
module gtmr_prescaler #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV <= 1) begin : g_nodiv
            assign tick = 1'b1;
        end else begin : g_div
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] ph_q;
            always_ff @(posedge clk) begin
                if (rst)               ph_q <= '0;
                else if (ph_q == LAST) ph_q <= '0;
                else                   ph_q <= ph_q + 1'b1;
            end
            assign tick = (ph_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/gtmr_edge_sync.sv
module gtmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign fall = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/gtmr_count_core.sv
module gtmr_count_core
    import gtmr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic          mode13,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] lo,
    output logic [DW-1:0] hi,
    output logic          wrap
);
    count_nxt_t nxt;
    logic       any_wr;

    assign nxt    = count_step(mode13, lo, hi);
    assign any_wr = wr_lo | wr_hi;
    assign wrap   = step & ~any_wr & nxt.wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo <= '0;
            hi <= '0;
        end else if (any_wr) begin
            if (wr_lo) lo <= wr_data;
            if (wr_hi) hi <= wr_data;
        end else if (step) begin
            lo <= nxt.lo;
            hi <= nxt.hi;
        end
    end
endmodule

// File: rtl/gated_timer.sv
module gated_timer
    import gtmr_pkg::*;
#(
    parameter int PRESCALE    = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          gate_in,
    input  logic          cnt_in,
    output logic          ovf_flag
);
    ctrl_t         ctrl_q;
    ctrl_t         ctrl_wr;
    logic          slow_tick;
    logic          ext_fall;
    logic          run_en;
    logic          step;
    logic          mode13;
    logic          wr_ctrl, wr_lo, wr_hi;
    logic          wrap;
    logic [DW-1:0] cnt_lo, cnt_hi;

    assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
    assign wr_lo   = wr_en && (wr_addr == ADDR_LO);
    assign wr_hi   = wr_en && (wr_addr == ADDR_HI);
    assign ctrl_wr = ctrl_from_byte(wr_data);

    gtmr_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (slow_tick)
    );

    gtmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (cnt_in),
        .fall (ext_fall)
    );

    assign run_en = ctrl_q.run & (~ctrl_q.gate_en | gate_in);
    assign mode13 = (ctrl_q.mode == MODE_13);

    always_comb begin
        if (ctrl_q.ext_sel)   step = run_en & ext_fall;
        else if (ctrl_q.fast) step = run_en;
        else                  step = run_en & slow_tick;
    end

    gtmr_count_core u_core (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .mode13  (mode13),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wr_data (wr_data),
        .lo      (cnt_lo),
        .hi      (cnt_hi),
        .wrap    (wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q     <= ctrl_wr;
                ctrl_q.ovf <= ctrl_wr.ovf | wrap;
            end else if (wrap) begin
                ctrl_q.ovf <= 1'b1;
            end
        end
    end

    always_comb begin
        case (rd_addr)
            ADDR_CTRL: rd_data = ctrl_q;
            ADDR_LO:   rd_data = cnt_lo;
            ADDR_HI:   rd_data = cnt_hi;
            default:   rd_data = '0;
        endcase
    end

    assign ovf_flag = ctrl_q.ovf;
endmodule

// File: rtl/gtmr_checker.sv
module gtmr_checker
    import gtmr_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          gate_in,
    input logic          ovf_flag,
    input ctrl_t         ctrl,
    input logic          step,
    input logic [DW-1:0] lo,
    input logic [DW-1:0] hi
);
    logic cnt_wr;
    assign cnt_wr = wr_en && (wr_addr == ADDR_LO || wr_addr == ADDR_HI);

    assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run || (ctrl.gate_en && !gate_in)) && !cnt_wr
        |=> ($stable(lo) && $stable(hi)));

    assert_wide_increment_R6: assert property (@(posedge clk) disable iff (rst)
        step && (ctrl.mode != MODE_13) && !cnt_wr
        |=> ({hi, lo} == $past({hi, lo}) + 16'd1));

    assert_top_bits_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == MODE_13) && !cnt_wr
        |=> (lo[DW-1:LO13_W] == $past(lo[DW-1:LO13_W])));

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        ovf_flag && !(wr_en && wr_addr == ADDR_CTRL && !wr_data[DW-1])
        |=> ovf_flag);

    assert_low_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
        wr_en && (wr_addr == ADDR_LO)
        |=> (lo == $past(wr_data) && hi == $past(hi)));
endmodule

bind gated_timer gtmr_checker chk_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .gate_in  (gate_in),
    .ovf_flag (ovf_flag),
    .ctrl     (ctrl_q),
    .step     (step),
    .lo       (cnt_lo),
    .hi       (cnt_hi)
);

// File: tb/gated_timer_tb.sv
module gated_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       gate_in = 1'b0;
    logic       cnt_in = 1'b1;
    logic       ovf_flag;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    gated_timer dut_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .gate_in  (gate_in),
        .cnt_in   (cnt_in),
        .ovf_flag (ovf_flag)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // Called at a negedge; consumes exactly one rising edge.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_cnt(input string tag, input logic [7:0] elo, input logic [7:0] ehi);
        logic [7:0] v;
        rd(2'd1, v); check({tag, " low"}, v, elo);
        rd(2'd2, v); check({tag, " high"}, v, ehi);
    endtask

    task automatic load(input logic [7:0] l, input logic [7:0] h);
        wr(2'd1, l);
        wr(2'd2, h);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(2'd0, v); check("R1 ctrl", v, 0);
        check_cnt("R1 count", 8'h00, 8'h00);
        rd(2'd3, v); check("R1 addr3", v, 0);
        check("R1 flag", ovf_flag, 0);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        load(8'h5A, 8'hC3);
        wr(2'd0, 8'h2D);
        rd(2'd0, v); check("R2 ctrl readback", v, 8'h2D);
        check_cnt("R2 count kept", 8'h5A, 8'hC3);
        wr(2'd0, 8'h40);
        rd(2'd0, v); check("R2 reserved bit", v, 8'h00);
        wait_cyc(5);
        check_cnt("R3 stopped holds", 8'h5A, 8'hC3);
    endtask

    task automatic t_run16();
        load(8'hF0, 8'h12);
        wr(2'd0, 8'h31);
        wait_cyc(20);
        check_cnt("R4 fast 16-bit", 8'h04, 8'h13);
        wr(2'd0, 8'h21);
        wait_cyc(10);
        check_cnt("R3 run cleared", 8'h05, 8'h13);
    endtask

    task automatic t_wrap16();
        load(8'hFE, 8'hFF);
        wr(2'd0, 8'h31);
        wait_cyc(1);
        check_cnt("R6 at ffff", 8'hFF, 8'hFF);
        check("R8 no flag yet", ovf_flag, 0);
        wait_cyc(1);
        check_cnt("R6 wrap", 8'h00, 8'h00);
        check("R8 flag set", ovf_flag, 1);
        wr(2'd0, 8'hA1);
        wait_cyc(5);
        check("R8 flag sticky", ovf_flag, 1);
        check_cnt("R6 after wrap", 8'h01, 8'h00);
        wr(2'd0, 8'h21);
        check("R8 flag cleared", ovf_flag, 0);
    endtask

    task automatic t_mode13();
        load(8'hFE, 8'hFF);
        wr(2'd0, 8'h30);
        wait_cyc(1);
        check_cnt("R7 13-bit top", 8'hFF, 8'hFF);
        wait_cyc(1);
        check_cnt("R7 13-bit wrap keeps upper", 8'hE0, 8'h00);
        check("R8 flag 13-bit", ovf_flag, 1);
        wr(2'd0, 8'h80);
        check_cnt("R7 stop", 8'hE1, 8'h00);
        wr(2'd0, 8'h00);
        load(8'hBF, 8'h05);
        wr(2'd0, 8'h30);
        wait_cyc(1);
        check_cnt("R7 carry into high", 8'hA0, 8'h06);
        wr(2'd0, 8'h00);
        check("R8 no false flag", ovf_flag, 0);
    endtask

    task automatic t_gate();
        load(8'h00, 8'h00);
        gate_in = 1'b0;
        wr(2'd0, 8'h39);
        wait_cyc(10);
        check_cnt("R3 gate low holds", 8'h00, 8'h00);
        gate_in = 1'b1;
        wait_cyc(5);
        check_cnt("R3 gate high counts", 8'h05, 8'h00);
        gate_in = 1'b0;
        wait_cyc(5);
        wr(2'd0, 8'h00);
        check_cnt("R3 gate closed", 8'h05, 8'h00);
    endtask

    task automatic t_div12();
        load(8'h00, 8'h00);
        wr(2'd0, 8'h11);
        wait_cyc(119);
        wr(2'd0, 8'h01);
        check_cnt("R4 divide by 12", 8'h0A, 8'h00);
    endtask

    task automatic t_ext();
        load(8'h00, 8'h00);
        cnt_in = 1'b1;
        wr(2'd0, 8'h35);
        wait_cyc(10);
        check_cnt("R5 internal tick ignored", 8'h00, 8'h00);
        for (int i = 0; i < 7; i++) begin
            cnt_in = 1'b0; wait_cyc(2);
            cnt_in = 1'b1; wait_cyc(2);
        end
        wait_cyc(4);
        check_cnt("R5 seven falling edges", 8'h07, 8'h00);
        cnt_in = 1'b0;
        wait_cyc(2);
        check_cnt("R5 latency not yet", 8'h07, 8'h00);
        wait_cyc(1);
        check_cnt("R5 latency three", 8'h08, 8'h00);
        cnt_in = 1'b1;
        wait_cyc(5);
        check_cnt("R5 rising ignored", 8'h08, 8'h00);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_collide_write();
        load(8'h00, 8'h33);
        wr(2'd0, 8'h31);
        wait_cyc(3);
        check_cnt("R9 pre", 8'h03, 8'h33);
        wr(2'd1, 8'h40);
        check_cnt("R9 low write wins", 8'h40, 8'h33);
        wait_cyc(1);
        check_cnt("R9 resumes", 8'h41, 8'h33);
        wr(2'd2, 8'h77);
        check_cnt("R9 high write wins", 8'h41, 8'h77);
        wr(2'd0, 8'h01);
        check_cnt("R9 after", 8'h42, 8'h77);
    endtask

    task automatic t_collide_flag();
        load(8'hFF, 8'hFF);
        wr(2'd0, 8'h31);
        wr(2'd0, 8'h31);
        check("R8 set beats clear", ovf_flag, 1);
        check_cnt("R8 wrapped", 8'h00, 8'h00);
        wr(2'd0, 8'h01);
        check("R8 clear later", ovf_flag, 0);
        check_cnt("R8 stop", 8'h01, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_run16();
        t_wrap16();
        t_mode13();
        t_gate();
        t_div12();
        t_ext();
        t_collide_write();
        t_collide_flag();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule